// File: doc/BRIEF.md
# Fine-Code Nonlinearity and Temperature Corrector

This block turns a raw fine code from a vernier interpolator into a corrected fine time, in fixed point with 1/16 ps units. Each code first goes through a per-code correction table that was calibrated at the reference temperature of -5 °C. Because the nonlinearity pattern repeats every clock period, the table is indexed by the fine code alone. The table value is then scaled by how much the bin width has grown between the reference temperature and the present one.

The bin width follows a linear model, 39.6 ps + 0.0807 ps/°C × (T + 5 °C). The scale factor is that width divided by the width at -5 °C. This makes it 1 + (0.0807/39.6)·(T + 5), which is linear in temperature, so it is formed from one fixed-point slope constant. The scale factor is held in a register and recomputed only when the temperature input changes, so the data path has no divider. A separate process builds the table and writes it in through a simple address/data/write-enable port before measurement starts.

Top module: `inl_temp_corrector`

## Requirements
- R1: When the pipeline is idle, a cycle with `tbl_we` high stores `tbl_data` at entry `tbl_addr`. Idle means `in_valid` is low in the current cycle and was low in the two cycles before it. Later codes equal to `tbl_addr` read the stored value.
- R2: A table write is ignored, and the entry keeps its old value, if `in_valid` is high in the same cycle or was high in either of the two cycles before it.
- R3: A code accepted with `in_valid` high in one cycle gives `out_valid` high exactly three cycles later. Back-to-back codes give back-to-back results in the same order, and `out_valid` is never high without a matching earlier input.
- R4: The result is `out_time = floor((E × S + 16384) / 32768)`. Here E is the 16-bit table entry for the code, and S is the 16-bit unsigned scale factor with 15 fraction bits.
- R5: For a clamped temperature Tc in whole °C, the scale factor is S = 32768 + floor((17095 × (Tc + 5) + 128) / 256). It runs from 32768 at -5 °C to 36775 at 55 °C.
- R6: The signed two's-complement `temperature` input is clamped to the range -5..55 before S is formed. Any value below -5 acts as -5, and any value above 55 acts as 55.
- R7: Each result uses the temperature that was presented in the same cycle as its code, even when the temperature changes every cycle.
- R8: After reset, `out_valid` and `out_time` are 0. `out_time` keeps its last result in every cycle where `out_valid` is low.
- R9: At the reference temperature (S = 32768), `out_time` equals the table entry exactly, including the entries 0 and 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Fine code present this cycle |
| in_code | input | 9 | Raw fine code (table index) |
| temperature | input | 8 | Signed operating temperature, whole °C |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 9 | Table entry to write |
| tbl_data | input | 16 | Reference-temperature time for that entry, 1/16 ps |
| out_valid | output | 1 | Corrected result present this cycle |
| out_time | output | 17 | Corrected fine time, 1/16 ps |

## Verification
The assertions check on every cycle that results leave the pipeline exactly three cycles after codes enter, with nothing spurious. They also check that the held scale factor stays within the model's range at the clamp ends, and that the output holds its value while no result is valid. Only the bench scenarios can show the numeric results. These include the effect of the clamp at extreme temperatures, the temperature-to-result pairing while the temperature changes every cycle, and whether a table write issued during or just after a burst of codes was dropped or kept.

// File: rtl/corr_pkg.sv
package corr_pkg;
   // Fixed-point conventions shared by the corrector
   localparam int TIME_FRAC_BITS = 4;   // times are in 1/16 ps
   localparam int SCALE_FRAC     = 15;  // scale factor is unsigned Q1.15
   localparam int SCALE_W        = 16;

   // Scale factor for an offset (in degrees) above the lower clamp end
   function automatic int scale_of(input int deg_above_min, input int slope_q8,
                                   input int frac);
      return (1 << frac) + ((slope_q8 * deg_above_min + 128) >>> 8);
   endfunction
endpackage

// File: rtl/corr_ratio_gen.sv
module corr_ratio_gen
   import corr_pkg::*;
#(
   parameter int TEMP_W   = 8,
   parameter int T_MIN    = -5,
   parameter int T_MAX    = 55,
   parameter int SLOPE_Q8 = 17095,
   parameter int RATIO_W  = SCALE_W,
   parameter int FRAC     = SCALE_FRAC
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic signed [TEMP_W-1:0]  temp,
   output logic [RATIO_W-1:0]        ratio
);
   localparam int SPAN      = T_MAX - T_MIN;
   localparam int RATIO_TOP = (1 << FRAC) + ((SLOPE_Q8 * SPAN + 128) >>> 8);

   if (T_MIN >= T_MAX) begin : g_bad_range
      $error("corr_ratio_gen: T_MIN must be below T_MAX");
   end
   if (T_MIN < -(1 << (TEMP_W - 1)) || T_MAX >= (1 << (TEMP_W - 1))) begin : g_bad_tw
      $error("corr_ratio_gen: clamp ends do not fit TEMP_W");
   end
   if (RATIO_TOP >= (1 << RATIO_W)) begin : g_bad_rw
      $error("corr_ratio_gen: scale factor overflows RATIO_W");
   end

   logic signed [TEMP_W-1:0] temp_seen;
   logic [RATIO_W-1:0]       ratio_q;
   int                       t_int;
   int                       t_clamped;
   int                       ratio_nxt;

   always_comb begin
      t_int = int'(temp);
      if (t_int < T_MIN)      t_clamped = T_MIN;
      else if (t_int > T_MAX) t_clamped = T_MAX;
      else                    t_clamped = t_int;
      ratio_nxt = scale_of(t_clamped - T_MIN, SLOPE_Q8, FRAC);
   end

   // recompute only on a temperature change
   always_ff @(posedge clk) begin
      if (rst) begin
         temp_seen <= TEMP_W'(T_MIN);
         ratio_q   <= RATIO_W'(1 << FRAC);
      end else if (temp != temp_seen) begin
         temp_seen <= temp;
         ratio_q   <= RATIO_W'(ratio_nxt);
      end
   end

   assign ratio = ratio_q;
endmodule

// File: rtl/corr_table.sv
module corr_table #(
   parameter int CODE_W = 9,
   parameter int TBL_W  = 16
) (
   input  logic              clk,
   input  logic              we,
   input  logic [CODE_W-1:0] waddr,
   input  logic [TBL_W-1:0]  wdata,
   input  logic              re,
   input  logic [CODE_W-1:0] raddr,
   output logic [TBL_W-1:0]  rdata
);
   localparam int DEPTH = 1 << CODE_W;

   if (CODE_W < 1 || CODE_W > 12) begin : g_bad_depth
      $error("corr_table: CODE_W out of supported range");
   end

   logic [TBL_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/corr_scale.sv
module corr_scale #(
   parameter int TBL_W         = 16,
   parameter int RATIO_W       = 16,
   parameter int FRAC          = 15,
   parameter int OUT_W         = 17,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_v,
   input  logic [TBL_W-1:0]   entry,
   input  logic [RATIO_W-1:0] ratio,
   output logic               mul_busy,
   output logic               out_v,
   output logic [OUT_W-1:0]   out_t
);
   localparam int PROD_W = TBL_W + RATIO_W;
   localparam logic [PROD_W:0] HALF = (PROD_W + 1)'(1) << (FRAC - 1);

   if (FRAC < 1 || FRAC + OUT_W > PROD_W + 1) begin : g_bad_fmt
      $error("corr_scale: FRAC/OUT_W do not fit the product");
   end

   logic              mul_v;
   logic [PROD_W-1:0] prod;
   logic [PROD_W:0]   rnd;

   // stage 2: multiply
   always_ff @(posedge clk) begin
      if (rst) begin
         mul_v <= 1'b0;
         prod  <= '0;
      end else begin
         mul_v <= in_v;
         if (in_v) prod <= PROD_W'(entry) * PROD_W'(ratio);
      end
   end

   if (ROUND_NEAREST) begin : g_round
      assign rnd = {1'b0, prod} + HALF;
   end else begin : g_trunc
      assign rnd = {1'b0, prod};
   end

   // stage 3: round and hold
   always_ff @(posedge clk) begin
      if (rst) begin
         out_v <= 1'b0;
         out_t <= '0;
      end else begin
         out_v <= mul_v;
         if (mul_v) out_t <= OUT_W'(rnd >> FRAC);
      end
   end

   assign mul_busy = mul_v;
endmodule

// File: rtl/inl_temp_corrector.sv
module inl_temp_corrector
   import corr_pkg::*;
#(
   parameter int CODE_W        = 9,
   parameter int TBL_W         = 16,
   parameter int TEMP_W        = 8,
   parameter int T_MIN         = -5,
   parameter int T_MAX         = 55,
   parameter int SLOPE_Q8      = 17095,
   parameter bit ROUND_NEAREST = 1'b1,
   localparam int RATIO_W      = SCALE_W,
   localparam int FRAC         = SCALE_FRAC,
   localparam int OUT_W        = TBL_W + 1,
   localparam int RATIO_MIN    = 1 << FRAC,
   localparam int RATIO_MAX    = (1 << FRAC) + ((SLOPE_Q8 * (T_MAX - T_MIN) + 128) >>> 8)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   input  logic [CODE_W-1:0]        in_code,
   input  logic signed [TEMP_W-1:0] temperature,
   input  logic                     tbl_we,
   input  logic [CODE_W-1:0]        tbl_addr,
   input  logic [TBL_W-1:0]         tbl_data,
   output logic                     out_valid,
   output logic [OUT_W-1:0]         out_time
);
   if (RATIO_MAX >= (1 << (FRAC + 1))) begin : g_bad_gain
      $error("inl_temp_corrector: scale above 2.0 does not fit OUT_W");
   end

   logic               rd_v;
   logic [TBL_W-1:0]   rd_entry;
   logic [RATIO_W-1:0] ratio_q;
   logic               mul_busy;
   logic               path_busy;
   logic               wr_ok;

   assign path_busy = in_valid | rd_v | mul_busy;
   assign wr_ok     = tbl_we & ~path_busy;

   corr_ratio_gen #(
      .TEMP_W(TEMP_W), .T_MIN(T_MIN), .T_MAX(T_MAX),
      .SLOPE_Q8(SLOPE_Q8), .RATIO_W(RATIO_W), .FRAC(FRAC)
   ) u_ratio (
      .clk(clk), .rst(rst), .temp(temperature), .ratio(ratio_q)
   );

   // stage 1: table read
   corr_table #(.CODE_W(CODE_W), .TBL_W(TBL_W)) u_table (
      .clk(clk), .we(wr_ok), .waddr(tbl_addr), .wdata(tbl_data),
      .re(in_valid), .raddr(in_code), .rdata(rd_entry)
   );

   always_ff @(posedge clk) begin
      if (rst) rd_v <= 1'b0;
      else     rd_v <= in_valid;
   end

   corr_scale #(
      .TBL_W(TBL_W), .RATIO_W(RATIO_W), .FRAC(FRAC),
      .OUT_W(OUT_W), .ROUND_NEAREST(ROUND_NEAREST)
   ) u_scale (
      .clk(clk), .rst(rst), .in_v(rd_v), .entry(rd_entry), .ratio(ratio_q),
      .mul_busy(mul_busy), .out_v(out_valid), .out_t(out_time)
   );
endmodule

// File: rtl/corr_chk.sv
module corr_chk #(
   parameter int OUT_W     = 17,
   parameter int RATIO_W   = 16,
   parameter int RATIO_MIN = 32768,
   parameter int RATIO_MAX = 36775
) (
   input logic               clk,
   input logic               rst,
   input logic               in_valid,
   input logic               out_valid,
   input logic [OUT_W-1:0]   out_time,
   input logic [RATIO_W-1:0] ratio
);
   // R3
   result_latency_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> ##3 out_valid);

   // R3
   no_spurious_result_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |-> ##3 !out_valid);

   // R5
   scale_range_chk: assert property (@(posedge clk) disable iff (rst)
      (int'(ratio) >= RATIO_MIN) && (int'(ratio) <= RATIO_MAX));

   // R8
   output_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> $stable(out_time));
endmodule

bind inl_temp_corrector corr_chk #(
   .OUT_W(OUT_W), .RATIO_W(RATIO_W), .RATIO_MIN(RATIO_MIN), .RATIO_MAX(RATIO_MAX)
) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
   .out_time(out_time), .ratio(ratio_q)
);

// File: tb/inl_temp_corrector_test.sv
module inl_temp_corrector_test;
   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              in_valid = 1'b0;
   logic [8:0]        in_code = '0;
   logic signed [7:0] temperature = -8'sd5;
   logic              tbl_we = 1'b0;
   logic [8:0]        tbl_addr = '0;
   logic [15:0]       tbl_data = '0;
   logic              out_valid;
   logic [16:0]       out_time;

   always #2 clk = ~clk;

   inl_temp_corrector uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code),
      .temperature(temperature), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
      .tbl_data(tbl_data), .out_valid(out_valid), .out_time(out_time)
   );

   int    checks = 0;
   int    fails = 0;
   int    cycles = 0;
   string cur_req = "R8";
   bit    done = 1'b0;

   // behavioural reference model
   int    mtbl [512];
   bit    pv [3];
   int    pt [3];
   bit    h1, h2;
   bit    exp_v;
   int    exp_t;

   function automatic int model_scale(int t);
      int tc;
      tc = t;
      if (tc < -5) tc = -5;   // R6
      if (tc > 55) tc = 55;
      return 32768 + (17095 * (tc + 5) + 128) / 256;   // R5
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         pv = '{0, 0, 0};
         h1 = 0; h2 = 0; exp_v = 0; exp_t = 0;
      end else begin
         bit busy;
         int val;
         longint p;
         busy = in_valid || h1 || h2;
         val = 0;
         if (in_valid) begin
            p = longint'(mtbl[in_code]) * longint'(model_scale(int'(temperature)));
            val = int'((p + 16384) / 32768);   // R4
         end
         if (tbl_we && !busy) mtbl[tbl_addr] = int'(tbl_data);   // R1 / R2
         h2 = h1; h1 = in_valid;
         pv[2] = pv[1]; pt[2] = pt[1];
         pv[1] = pv[0]; pt[1] = pt[0];
         pv[0] = in_valid; pt[0] = val;
         exp_v = pv[2];
         if (exp_v) exp_t = pt[2];
      end
   end

   always @(negedge clk) begin
      if (!rst && !done) begin
         checks++;
         if (out_valid !== exp_v) begin
            fails++;
            $display("FAIL %s: out_valid=%0d expected %0d at cycle %0d", cur_req, out_valid, exp_v, cycles);
         end
         checks++;
         if (out_time !== 17'(exp_t)) begin
            fails++;
            $display("FAIL %s: out_time=%0d expected %0d at cycle %0d", cur_req, out_time, exp_t, cycles);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog: run did not finish, actual %0d cycles expected under 20000", cycles);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 0; tbl_we = 0;
      end
   endtask

   task automatic load(int a, int d);
      @(negedge clk);
      in_valid = 0; tbl_we = 1; tbl_addr = 9'(a); tbl_data = 16'(d);
   endtask

   task automatic send(int code, int t);
      @(negedge clk);
      tbl_we = 0; in_valid = 1; in_code = 9'(code); temperature = 8'(t);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      // R8: reset state
      @(negedge clk);
      cur_req = "R8";
      checks++;
      if (out_valid !== 1'b0 || out_time !== 17'd0) begin
         fails++;
         $display("FAIL R8: reset outputs %0d/%0d expected 0/0", out_valid, out_time);
      end

      // R1: table load while idle
      cur_req = "R1";
      for (int i = 0; i < 512; i++) load(i, (i * 97 + 1000) % 65536);
      load(0, 0);
      load(511, 65535);
      idle(3);

      // R9: identity at the reference temperature
      cur_req = "R9";
      for (int i = 0; i < 12; i++) send(i, -5);
      send(511, -5);
      send(0, -5);
      idle(5);

      // R4 / R5: scaling at the hot end and mid range, back to back
      cur_req = "R4";
      for (int i = 0; i < 10; i++) send(500 - i * 7, 55);
      send(511, 55);
      for (int i = 0; i < 10; i++) send(i * 40, 20);
      idle(2);
      cur_req = "R3";
      send(77, 30); idle(1); send(78, 30); send(79, 31); idle(5);

      // R6: clamp below and above the range
      cur_req = "R6";
      send(511, 100); send(300, -40); send(511, 127); send(300, -128); send(12, 56); send(12, -6);
      idle(5);

      // R7: temperature changes every cycle alongside codes
      cur_req = "R7";
      for (int i = 0; i < 40; i++) send(i * 13, -10 + i * 2);
      idle(5);

      // R2: writes during and right after a code are dropped; R1 once idle
      cur_req = "R2";
      @(negedge clk);
      in_valid = 1; in_code = 9'd5; temperature = 8'sd10;
      tbl_we = 1; tbl_addr = 9'd100; tbl_data = 16'd1;
      load(101, 2);
      load(102, 3);
      cur_req = "R1";
      load(103, 4);
      idle(3);
      cur_req = "R2";
      send(100, -5); send(101, -5); send(102, -5);
      cur_req = "R1";
      send(103, -5);
      idle(6);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule